// File: doc/BRIEF.md
# Cascaded Interrupt Status Aggregator

This block gathers interrupt requests from two kinds of sources into one ten-bit status word and drives a single interrupt line to the host. The low four status bits summarise four GPIO banks. Each one follows its bank's pending line directly, and it goes away only when the host services the bank. The upper six bits belong to direct sources. Each of these captures a rising edge on its source line and holds it until the host writes a one to that bit.

An enable register selects which status bits may reach the output. Setting a bit enables that source. A separate global enable bit must also be set before anything can raise the output. The output is registered. It is high while the global enable is set and at least one enabled status bit is pending. It falls as soon as nothing enabled is pending, so each new batch of work gives the host a fresh rising edge.

The host reaches both registers through a single-cycle write port and a combinational read port, selected by a one-bit address.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the status word reads zero when no source is active, the enable register reads zero, and the interrupt output is low.
- R2: Status bits 3:0 (address 0) always show the current level of the four bank pending inputs, with bank index i at bit i.
- R3: Writes to address 0 have no effect on status bits 3:0.
- R4: A rising edge on direct source j sets status bit 4+j on the following clock edge. A source held high does not set the bit again after it has been cleared.
- R5: Writing address 0 with a one at bit 4+j clears that direct bit on the next clock edge. Writing a zero there leaves the bit unchanged.
- R6: If a rising edge and a clearing write hit the same direct bit in the same cycle, the bit ends up set.
- R7: The enable register (address 1) holds a per-source enable in bits 9:0 (1 = enabled) and the global enable in bit 15. Its other bits read as zero.
- R8: One clock after the global enable is set and any status bit is set together with its enable bit, the interrupt output is high.
- R9: While the global enable is clear, the interrupt output is low on the next clock, whatever is pending.
- R10: One clock after no enabled status bit is pending, the output is low, so the next pending event produces a new rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_pend_i | input | 4 | Pending summary lines from the GPIO banks |
| direct_src_i | input | 6 | Direct interrupt source lines (edge captured) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 status, 1 enable |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request to the host, registered |

## Verification
The hardest case to reach from the ports is a clearing write that arrives in the same cycle as a fresh rising edge on the same direct source. The stimulus first latches the bit, drops the source, and then raises it again in exactly the cycle the clearing write is driven, after which the status word is read. A second awkward case is a source that stays high across its own clear. The bench holds it high for several cycles after the write and checks that the bit stays clear. The bank side is swept over every combination of the four pending lines against every combination of the four bank enables.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int REG_W      = 16;
    localparam int GLOBAL_BIT = 15;
    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_ENABLE = 1'b1;
endpackage

// File: rtl/irq_direct_latch.sv
module irq_direct_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_i;
        // a new edge takes priority over a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr_i) | (src_i & ~st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_agg_pkg::*;
#(
    parameter int STAT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [STAT_W-1:0] en_o,
    output logic              glb_o
);
    typedef struct packed {
        logic              glb;
        logic [STAT_W-1:0] en;
    } en_t;

    en_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.en  = wdata_i[STAT_W-1:0];
            st_d.glb = wdata_i[GLOBAL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign glb_o = st_q.glb;
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
    parameter int STAT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [STAT_W-1:0] en_i,
    input  logic              glb_i,
    output logic              irq_o
);
    typedef struct packed {
        logic irq;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = glb_i && (|(stat_i & en_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int NUM_DIRECT = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BANKS-1:0]  bank_pend_i,
    input  logic [NUM_DIRECT-1:0] direct_src_i,
    input  logic                  wr_en_i,
    input  logic                  addr_i,
    input  logic [REG_W-1:0]      wdata_i,
    output logic [REG_W-1:0]      rdata_o,
    output logic                  irq_o
);
    localparam int STAT_W = NUM_BANKS + NUM_DIRECT;

    logic [NUM_DIRECT-1:0] dir_pend;
    logic [NUM_DIRECT-1:0] dir_clr;
    logic [STAT_W-1:0]     status_w;
    logic [STAT_W-1:0]     en_w;
    logic                  glb_w;
    logic                  wr_stat;
    logic                  wr_en_reg;
    logic                  unused_wbits;

    assign wr_stat   = wr_en_i && (addr_i == ADDR_STATUS);
    assign wr_en_reg = wr_en_i && (addr_i == ADDR_ENABLE);
    assign dir_clr   = wr_stat ? wdata_i[STAT_W-1:NUM_BANKS] : '0;
    assign unused_wbits = ^wdata_i;

    irq_direct_latch #(.N(NUM_DIRECT)) dir_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (direct_src_i),
        .clr_i  (dir_clr),
        .pend_o (dir_pend)
    );

    irq_enable_reg #(.STAT_W(STAT_W)) en_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en_reg),
        .wdata_i (wdata_i),
        .en_o    (en_w),
        .glb_o   (glb_w)
    );

    assign status_w = {dir_pend, bank_pend_i};

    irq_out_gen #(.STAT_W(STAT_W)) out_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (status_w),
        .en_i   (en_w),
        .glb_i  (glb_w),
        .irq_o  (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_STATUS) begin
            rdata_o[STAT_W-1:0] = status_w;
        end else begin
            rdata_o[STAT_W-1:0] = en_w;
            rdata_o[GLOBAL_BIT] = glb_w;
        end
    end
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
    parameter int NB = 4,
    parameter int ND = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ND-1:0]    src,
    input logic             wr,
    input logic             addr,
    input logic [15:0]      wdata,
    input logic [NB+ND-1:0] stat,
    input logic [NB+ND-1:0] en,
    input logic             glb,
    input logic             irq
);
    logic [ND-1:0] src_prev;
    logic [ND-1:0] rise;
    logic [ND-1:0] clr_req;

    always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src;
    end

    assign rise    = src & ~src_prev;
    assign clr_req = (wr && addr == 1'b0) ? wdata[NB+ND-1:NB] : '0;

    assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((stat[NB+ND-1:NB] & $past(rise)) == $past(rise)));

    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_req & ~rise)) |=> ((stat[NB+ND-1:NB] & $past(clr_req & ~rise)) == '0));

    assert_pending_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (glb && (|(stat & en))) |=> irq);

    assert_global_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !glb |=> !irq);

    assert_idle_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat & en)) |=> !irq);
endmodule

bind irq_status_agg irq_status_agg_chk #(.NB(NUM_BANKS), .ND(NUM_DIRECT)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (direct_src_i),
    .wr    (wr_en_i),
    .addr  (addr_i),
    .wdata (wdata_i),
    .stat  (status_w),
    .en    (en_w),
    .glb   (glb_w),
    .irq   (irq_o)
);

// File: tb/irq_status_agg_tb_top.sv
module irq_status_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bank;
    logic [5:0]  src;
    logic        wr;
    logic        addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_status_agg dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_pend_i  (bank),
        .direct_src_i (src),
        .wr_en_i      (wr),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .irq_o        (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wreg(input logic a, input logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rreg(input logic a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        rst_n = 1'b0; bank = '0; src = '0; wr = 1'b0; addr = 1'b0; wdata = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        rreg(1'b0, rv); check("R1 status", rv, 16'h0);
        rreg(1'b1, rv); check("R1 enable", rv, 16'h0);
        check("R1 irq", irq, 1'b0);

        // R7 enable readback
        wreg(1'b1, 16'hFFFF);
        rreg(1'b1, rv); check("R7 readback all", rv, 16'h83FF);
        wreg(1'b1, 16'h7C00);
        rreg(1'b1, rv); check("R7 unused bits", rv, 16'h0000);

        // R2/R8/R10 bank sweep: all pending patterns against all bank enables
        for (int m = 0; m < 16; m++) begin
            for (int b = 0; b < 16; b++) begin
                bank = b[3:0];
                wreg(1'b1, 16'h8000 | 16'(m));
                step();
                rreg(1'b0, rv);
                check("R2 bank live", rv, 16'(b));
                check("R8 R10 bank irq", irq, ((b & m) != 0));
            end
        end

        // R3 writes to bank bits ignored
        bank = 4'b0000;
        wreg(1'b0, 16'h000F);
        rreg(1'b0, rv); check("R3 write ones ignored", rv, 16'h0);
        bank = 4'b1010;
        wreg(1'b0, 16'h0000);
        rreg(1'b0, rv); check("R3 write zeros ignored", rv, 16'h000A);

        // R9 global enable clear blocks everything
        wreg(1'b1, 16'h03FF);
        bank = 4'hF;
        step(); step();
        check("R9 global off", irq, 1'b0);
        bank = 4'h0;
        wreg(1'b1, 16'h0000);

        // R4/R5 per direct source
        for (int j = 0; j < 6; j++) begin
            src[j] = 1'b1;
            step();
            rreg(1'b0, rv); check("R4 edge latched", rv, 16'(1 << (4 + j)));
            // held high, then cleared: must stay clear
            wreg(1'b0, 16'h0000);
            rreg(1'b0, rv); check("R5 write zero keeps", rv, 16'(1 << (4 + j)));
            wreg(1'b0, 16'(1 << (4 + j)));
            step(); step();
            rreg(1'b0, rv); check("R4 R5 clear while held", rv, 16'h0);
            src[j] = 1'b0;
            step();
        end

        // R6 simultaneous edge and clear
        src[2] = 1'b1; step(); src[2] = 1'b0; step();
        rreg(1'b0, rv); check("R6 pre set", rv, 16'h0040);
        src[2] = 1'b1;
        wreg(1'b0, 16'h0040);
        rreg(1'b0, rv); check("R6 set wins", rv, 16'h0040);
        src[2] = 1'b0;
        wreg(1'b0, 16'h0040);
        rreg(1'b0, rv); check("R6 cleared after", rv, 16'h0);

        // R8/R10 direct source edges on output
        wreg(1'b1, 16'h8000 | 16'h0200);
        src[5] = 1'b1; step();
        check("R10 irq not yet", irq, 1'b0);
        step();
        check("R8 irq from direct", irq, 1'b1);
        wreg(1'b0, 16'h0200);
        step();
        check("R10 irq drops", irq, 1'b0);
        src[5] = 1'b0; step();
        src[5] = 1'b1; step(); step();
        check("R10 new rising", irq, 1'b1);
        src[0] = 1'b1; step(); step();
        check("R8 disabled source no effect", irq, 1'b1);
        wreg(1'b0, 16'h0200); step();
        check("R8 disabled source alone", irq, 1'b0);
        src = '0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule